// File: doc/BRIEF.md
# Data-Space Register Alias Decoder

This block sits on the byte-wide load/store path of a small 8-bit microcontroller. It inspects every data-space access and decides where it goes. The lowest addresses reach the general register file. A short window of eight addresses reaches the special registers: four extended-address page registers, an indirect-jump extension register, the two stack pointer bytes and the status byte. Every other address goes out unchanged to the data RAM port.

The block accepts requests on a valid/ready channel. A register access is always accepted in the cycle it is presented. A RAM access is accepted only when the RAM port is ready, so RAM back-pressure passes straight back to the requester. Read data comes back on a response channel one cycle after acceptance, for both register and RAM reads. The response channel has no ready, so the requester must always take a response.

The page registers keep their byte pre-shifted into bits 23:16 of a 24-bit value, which the address generators use directly. Strap inputs switch off writes to individual page registers and to the stack pointer high byte. A disabled write is dropped without any error.

Top module: `dspace_alias_decoder`

## Requirements
- R1: Data addresses 0x00–0x1F read and write general register N at address N. The core-side port `core_gpr_data` shows the register chosen by `core_gpr_sel`.
- R2: Addresses 0x58, 0x59, 0x5A, 0x5B and 0x5C select the D, X, Y, Z page registers and the jump extension register. A write stores the byte in bits 23:16 with zeros in bits 15:0. A read returns bits 23:16.
- R3: A write to 0x58–0x5B is dropped when the strap for that page register is low, and the register keeps its old value.
- R4: The jump extension register at 0x5C is always writable, whatever the straps.
- R5: A write to 0x5D replaces bits 7:0 of `stack_ptr` and leaves bits 15:8 unchanged.
- R6: A write to 0x5E replaces bits 15:8 of `stack_ptr` only when `strap_sp16` is high. Otherwise it is dropped.
- R7: Address 0x5F reads and writes the status byte, which is shown on `status_byte`.
- R8: Every other address is forwarded on the RAM port with its write flag, address and data unchanged, and `req_ready` follows `ram_ready`. A register access never raises `ram_valid`.
- R9: A register access is accepted in the cycle it is presented. A register read gives `rsp_valid` with the data in the next cycle.
- R10: After reset, all page registers, the stack pointer, the status byte and the general registers are zero, and no response is pending.
- R11: A RAM read response (`ram_rsp_valid`, `ram_rsp_data`) appears on `rsp_valid`/`rsp_data` in the same cycle. The RAM is expected to answer one cycle after it accepts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_page_d | input | 1 | Enables writes to the D page register |
| strap_page_x | input | 1 | Enables writes to the X page register |
| strap_page_y | input | 1 | Enables writes to the Y page register |
| strap_page_z | input | 1 | Enables writes to the Z page register |
| strap_sp16 | input | 1 | Enables writes to the stack pointer high byte |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 8 | Load data |
| ram_valid | output | 1 | Forwarded RAM request valid |
| ram_ready | input | 1 | RAM accepts request |
| ram_write | output | 1 | Forwarded store flag |
| ram_addr | output | 16 | Forwarded address |
| ram_wdata | output | 8 | Forwarded store data |
| ram_rsp_valid | input | 1 | RAM load data valid |
| ram_rsp_data | input | 8 | RAM load data |
| core_gpr_sel | input | 5 | Core-side general register select |
| core_gpr_data | output | 8 | Core-side general register value |
| page_d | output | 24 | D page register, byte in 23:16 |
| page_x | output | 24 | X page register, byte in 23:16 |
| page_y | output | 24 | Y page register, byte in 23:16 |
| page_z | output | 24 | Z page register, byte in 23:16 |
| page_ext | output | 24 | Jump extension register, byte in 23:16 |
| stack_ptr | output | 16 | Stack pointer |
| status_byte | output | 8 | Status byte |

## Verification
The bench writes a distinct byte to every address from 0x00 to 0x7F and reads them all back. It does this once with every strap high and no RAM stall, and once with every strap low and the RAM ready only every other cycle. This covers the window edges: 0x1F against 0x20, and 0x57 and 0x60 around the special window. A decoder with an off-by-one bound would send one of these to the wrong storage, and the read-back would show it. With the straps low, a design that ignored a strap would overwrite a page register or the stack pointer high byte. One that gated the jump extension register or the low stack byte with a strap would keep a stale value. A stack pointer low-byte write that disturbed the high byte shows up in a focused sequence, and so does a register read whose response came a cycle late or went to the RAM port.

// File: rtl/dspace_alias_pkg.sv
package dspace_alias_pkg;

  typedef enum logic [1:0] {
    REGION_GPR     = 2'd0,
    REGION_SPECIAL = 2'd1,
    REGION_RAM     = 2'd2
  } region_e;

  // Special window slot order; the address decoder relies on it.
  localparam int SLOT_PAGE_D = 0;
  localparam int SLOT_PAGE_X = 1;
  localparam int SLOT_PAGE_Y = 2;
  localparam int SLOT_PAGE_Z = 3;
  localparam int SLOT_EXT    = 4;
  localparam int SLOT_SP_LO  = 5;
  localparam int SLOT_SP_HI  = 6;
  localparam int SLOT_STATUS = 7;

  localparam int NUM_SLOTS      = 8;
  localparam int NUM_PAGE_REGS  = 5;
  localparam int NUM_STRAPPED   = 4;

endpackage

// File: rtl/dspace_region_decode.sv
module dspace_region_decode
  import dspace_alias_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_GPR      = 32,
  parameter int SPECIAL_BASE = 32'h58
) (
  input  logic [ADDR_W-1:0]          addr,
  output region_e                    region,
  output logic [$clog2(NUM_GPR)-1:0] gpr_idx,
  output logic [2:0]                 slot_idx
);

  localparam int GPR_IDX_W = $clog2(NUM_GPR);
  localparam logic [ADDR_W-1:0] GPR_LIMIT  = ADDR_W'(NUM_GPR);
  localparam logic [ADDR_W-1:0] SPEC_BASE  = ADDR_W'(SPECIAL_BASE);
  localparam logic [ADDR_W-1:0] SPEC_COUNT = ADDR_W'(NUM_SLOTS);

  logic [ADDR_W-1:0] spec_off;

  always_comb begin
    spec_off = addr - SPEC_BASE;
    gpr_idx  = addr[GPR_IDX_W-1:0];
    slot_idx = spec_off[2:0];
    if (addr < GPR_LIMIT) begin
      region = REGION_GPR;
    end else if (spec_off < SPEC_COUNT) begin
      region = REGION_SPECIAL;
    end else begin
      region = REGION_RAM;
    end
  end

endmodule

// File: rtl/dspace_gpr_bank.sv
module dspace_gpr_bank #(
  parameter int NUM_GPR = 32,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_GPR)-1:0] acc_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          acc_rdata,
  input  logic [$clog2(NUM_GPR)-1:0] core_idx,
  output logic [DATA_W-1:0]          core_rdata
);

  localparam int IDX_W = $clog2(NUM_GPR);

  logic [DATA_W-1:0] gpr_q [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gpr_q[g] <= '0;
      end else if (wr_en && (acc_idx == IDX_W'(g))) begin
        gpr_q[g] <= wr_data;
      end
    end
  end

  assign acc_rdata  = gpr_q[acc_idx];
  assign core_rdata = gpr_q[core_idx];

endmodule

// File: rtl/dspace_special_bank.sv
module dspace_special_bank
  import dspace_alias_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 24,
  parameter int PAGE_SHIFT = 16,
  parameter int SP_W       = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [2:0]                        slot,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [NUM_STRAPPED-1:0]           page_strap,
  input  logic                              sp16_strap,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [NUM_PAGE_REGS*PAGE_W-1:0]   page_flat,
  output logic [SP_W-1:0]                   sp_out,
  output logic [DATA_W-1:0]                 status_out
);

  logic [PAGE_W-1:0] page_q    [NUM_PAGE_REGS];
  logic [DATA_W-1:0] page_byte [NUM_PAGE_REGS];
  logic [SP_W-1:0]   sp_q;
  logic [DATA_W-1:0] status_q;

  for (genvar p = 0; p < NUM_PAGE_REGS; p++) begin : g_page
    logic allow;
    if (p < NUM_STRAPPED) begin : g_strapped
      assign allow = page_strap[p];
    end else begin : g_free
      assign allow = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_q[p] <= '0;
      end else if (wr_en && allow && (slot == 3'(p))) begin
        page_q[p] <= PAGE_W'(wr_data) << PAGE_SHIFT;
      end
    end

    assign page_byte[p] = page_q[p][PAGE_SHIFT +: DATA_W];
    assign page_flat[p*PAGE_W +: PAGE_W] = page_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q     <= '0;
      status_q <= '0;
    end else if (wr_en) begin
      if (slot == 3'(SLOT_SP_LO)) begin
        sp_q[DATA_W-1:0] <= wr_data;
      end
      if ((slot == 3'(SLOT_SP_HI)) && sp16_strap) begin
        sp_q[SP_W-1:DATA_W] <= wr_data;
      end
      if (slot == 3'(SLOT_STATUS)) begin
        status_q <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PAGE_REGS; i++) begin
      if (slot == 3'(i)) begin
        rd_data = page_byte[i];
      end
    end
    if (slot == 3'(SLOT_SP_LO)) rd_data = sp_q[DATA_W-1:0];
    if (slot == 3'(SLOT_SP_HI)) rd_data = sp_q[SP_W-1:DATA_W];
    if (slot == 3'(SLOT_STATUS)) rd_data = status_q;
  end

  assign sp_out     = sp_q;
  assign status_out = status_q;

endmodule

// File: rtl/dspace_alias_decoder.sv
module dspace_alias_decoder
  import dspace_alias_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int NUM_GPR       = 32,
  parameter int IO_ALIAS_BASE = 32'h38,
  parameter int PAGE_W        = 24,
  parameter int PAGE_SHIFT    = 16,
  parameter int SP_W          = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strap_page_d,
  input  logic                       strap_page_x,
  input  logic                       strap_page_y,
  input  logic                       strap_page_z,
  input  logic                       strap_sp16,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data,
  output logic                       ram_valid,
  input  logic                       ram_ready,
  output logic                       ram_write,
  output logic [ADDR_W-1:0]          ram_addr,
  output logic [DATA_W-1:0]          ram_wdata,
  input  logic                       ram_rsp_valid,
  input  logic [DATA_W-1:0]          ram_rsp_data,
  input  logic [$clog2(NUM_GPR)-1:0] core_gpr_sel,
  output logic [DATA_W-1:0]          core_gpr_data,
  output logic [PAGE_W-1:0]          page_d,
  output logic [PAGE_W-1:0]          page_x,
  output logic [PAGE_W-1:0]          page_y,
  output logic [PAGE_W-1:0]          page_z,
  output logic [PAGE_W-1:0]          page_ext,
  output logic [SP_W-1:0]            stack_ptr,
  output logic [DATA_W-1:0]          status_byte
);

  localparam int GPR_IDX_W    = $clog2(NUM_GPR);
  localparam int SPECIAL_BASE = IO_ALIAS_BASE + NUM_GPR;

  region_e                         region;
  logic [GPR_IDX_W-1:0]            gpr_idx;
  logic [2:0]                      slot_idx;
  logic                            is_reg;
  logic                            accept;
  logic                            gpr_we;
  logic                            spec_we;
  logic [DATA_W-1:0]               gpr_rdata;
  logic [DATA_W-1:0]               spec_rdata;
  logic [NUM_PAGE_REGS*PAGE_W-1:0] page_flat;
  logic                            reg_rsp_valid_q;
  logic [DATA_W-1:0]               reg_rsp_data_q;

  dspace_region_decode #(
    .ADDR_W       (ADDR_W),
    .NUM_GPR      (NUM_GPR),
    .SPECIAL_BASE (SPECIAL_BASE)
  ) u_decode (
    .addr     (req_addr),
    .region   (region),
    .gpr_idx  (gpr_idx),
    .slot_idx (slot_idx)
  );

  assign is_reg    = (region != REGION_RAM);
  assign req_ready = is_reg | ram_ready;
  assign accept    = req_valid & req_ready;
  assign gpr_we    = accept & req_write & (region == REGION_GPR);
  assign spec_we   = accept & req_write & (region == REGION_SPECIAL);

  assign ram_valid = req_valid & ~is_reg;
  assign ram_write = req_write;
  assign ram_addr  = req_addr;
  assign ram_wdata = req_wdata;

  dspace_gpr_bank #(
    .NUM_GPR (NUM_GPR),
    .DATA_W  (DATA_W)
  ) u_gpr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (gpr_we),
    .acc_idx    (gpr_idx),
    .wr_data    (req_wdata),
    .acc_rdata  (gpr_rdata),
    .core_idx   (core_gpr_sel),
    .core_rdata (core_gpr_data)
  );

  dspace_special_bank #(
    .DATA_W     (DATA_W),
    .PAGE_W     (PAGE_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SP_W       (SP_W)
  ) u_special (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (spec_we),
    .slot       (slot_idx),
    .wr_data    (req_wdata),
    .page_strap ({strap_page_z, strap_page_y, strap_page_x, strap_page_d}),
    .sp16_strap (strap_sp16),
    .rd_data    (spec_rdata),
    .page_flat  (page_flat),
    .sp_out     (stack_ptr),
    .status_out (status_byte)
  );

  assign page_d   = page_flat[SLOT_PAGE_D*PAGE_W +: PAGE_W];
  assign page_x   = page_flat[SLOT_PAGE_X*PAGE_W +: PAGE_W];
  assign page_y   = page_flat[SLOT_PAGE_Y*PAGE_W +: PAGE_W];
  assign page_z   = page_flat[SLOT_PAGE_Z*PAGE_W +: PAGE_W];
  assign page_ext = page_flat[SLOT_EXT*PAGE_W +: PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rsp_valid_q <= 1'b0;
      reg_rsp_data_q  <= '0;
    end else begin
      reg_rsp_valid_q <= accept & ~req_write & is_reg;
      if (accept & ~req_write & is_reg) begin
        reg_rsp_data_q <= (region == REGION_GPR) ? gpr_rdata : spec_rdata;
      end
    end
  end

  assign rsp_valid = reg_rsp_valid_q | ram_rsp_valid;
  assign rsp_data  = reg_rsp_valid_q ? reg_rsp_data_q : ram_rsp_data;

endmodule

// File: rtl/dspace_alias_decoder_chk.sv
module dspace_alias_decoder_chk #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int NUM_GPR       = 32,
  parameter int IO_ALIAS_BASE = 32'h38,
  parameter int PAGE_W        = 24,
  parameter int SP_W          = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_page_d,
  input logic              strap_sp16,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              ram_valid,
  input logic [PAGE_W-1:0] page_d,
  input logic [SP_W-1:0]   stack_ptr,
  input logic [DATA_W-1:0] status_byte
);

  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(IO_ALIAS_BASE + NUM_GPR);
  localparam logic [ADDR_W-1:0] A_PGD   = BASE;
  localparam logic [ADDR_W-1:0] A_SPLO  = BASE + ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_SPHI  = BASE + ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_STAT  = BASE + ADDR_W'(7);
  localparam logic [ADDR_W-1:0] GPR_END = ADDR_W'(NUM_GPR);

  logic reg_addr;
  assign reg_addr = (req_addr < GPR_END) || ((req_addr >= BASE) && (req_addr <= A_STAT));

  // R8
  reg_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_addr) |-> (!ram_valid && req_ready));

  // R9
  reg_read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && reg_addr) |=> rsp_valid);

  // R3
  page_strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_PGD && !strap_page_d) |=> $stable(page_d));

  // R5
  sp_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_SPLO)
      |=> (stack_ptr[SP_W-1:DATA_W] == $past(stack_ptr[SP_W-1:DATA_W])
           && stack_ptr[DATA_W-1:0] == $past(req_wdata)));

  // R6
  sp_hi_strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_SPHI && !strap_sp16) |=> $stable(stack_ptr));

  // R7
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_STAT) |=> (status_byte == $past(req_wdata)));

endmodule

bind dspace_alias_decoder dspace_alias_decoder_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .NUM_GPR       (NUM_GPR),
  .IO_ALIAS_BASE (IO_ALIAS_BASE),
  .PAGE_W        (PAGE_W),
  .SP_W          (SP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strap_page_d (strap_page_d),
  .strap_sp16   (strap_sp16),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .ram_valid    (ram_valid),
  .page_d       (page_d),
  .stack_ptr    (stack_ptr),
  .status_byte  (status_byte)
);

// File: tb/dspace_alias_decoder_tb_top.sv
`timescale 1ns/1ps
module dspace_alias_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_page_d = 1'b1, strap_page_x = 1'b1, strap_page_y = 1'b1, strap_page_z = 1'b1;
  logic        strap_sp16 = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        ram_valid;
  logic        ram_ready;
  logic        ram_write;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_rsp_valid;
  logic [7:0]  ram_rsp_data;
  logic [4:0]  core_gpr_sel = '0;
  logic [7:0]  core_gpr_data;
  logic [23:0] page_d, page_x, page_y, page_z, page_ext;
  logic [15:0] stack_ptr;
  logic [7:0]  status_byte;

  int checks = 0;
  int errors = 0;
  logic stall_en = 1'b0;
  logic [7:0] cyc = '0;
  logic [7:0] ram_mem [256];
  logic [7:0] exp_mem [256];

  always #2 clk = ~clk;

  dspace_alias_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .strap_page_d(strap_page_d), .strap_page_x(strap_page_x),
    .strap_page_y(strap_page_y), .strap_page_z(strap_page_z), .strap_sp16(strap_sp16),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_write(ram_write),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rsp_valid(ram_rsp_valid), .ram_rsp_data(ram_rsp_data),
    .core_gpr_sel(core_gpr_sel), .core_gpr_data(core_gpr_data),
    .page_d(page_d), .page_x(page_x), .page_y(page_y), .page_z(page_z),
    .page_ext(page_ext), .stack_ptr(stack_ptr), .status_byte(status_byte)
  );

  // RAM model with one-cycle read latency
  assign ram_ready = stall_en ? cyc[0] : 1'b1;
  always_ff @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (ram_valid && ram_ready && !ram_write) begin
      ram_rsp_valid <= 1'b1;
      ram_rsp_data  <= ram_mem[ram_addr[7:0]];
    end else begin
      ram_rsp_valid <= 1'b0;
    end
    if (ram_valid && ram_ready && ram_write) ram_mem[ram_addr[7:0]] <= ram_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string req_of(input int a);
    if (a < 32) return "R1";
    if (a >= 'h58 && a <= 'h5B) return "R2/R3";
    if (a == 'h5C) return "R4";
    if (a == 'h5D) return "R5";
    if (a == 'h5E) return "R6";
    if (a == 'h5F) return "R7";
    return "R8/R11";
  endfunction

  function automatic bit is_reg_addr(input int a);
    return (a < 32) || (a >= 'h58 && a <= 'h5F);
  endfunction

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    check(is_reg_addr(int'(a)) ? "R8/R9 ram_valid" : "R8 ram_valid",
          {31'b0, ram_valid}, {31'b0, !is_reg_addr(int'(a))});
    if (!is_reg_addr(int'(a))) check("R8 ram_addr", {16'b0, ram_addr}, {16'b0, a});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = 8'h00;
    if (!wr) begin
      check(is_reg_addr(int'(a)) ? "R9 rsp_valid" : "R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
      rd = rsp_data;
    end
  endtask

  function automatic logic strap_for(input int a);
    case (a)
      'h58: return strap_page_d;
      'h59: return strap_page_x;
      'h5A: return strap_page_y;
      'h5B: return strap_page_z;
      'h5E: return strap_sp16;
      default: return 1'b1;
    endcase
  endfunction

  task automatic sweep(input int mul, input int add);
    logic [7:0] rd;
    for (int a = 0; a < 128; a++) begin
      logic [7:0] d;
      d = 8'((a * mul + add) & 255);
      access(1'b1, 16'(a), d, rd);
      if (strap_for(a)) exp_mem[a] = d;
    end
    for (int a = 0; a < 128; a++) begin
      access(1'b0, 16'(a), 8'h00, rd);
      check(req_of(a), {24'b0, rd}, {24'b0, exp_mem[a]});
    end
    for (int i = 0; i < 32; i++) begin
      core_gpr_sel = 5'(i);
      #1;
      check("R1 core port", {24'b0, core_gpr_data}, {24'b0, exp_mem[i]});
    end
    check("R2 page_d", {8'b0, page_d}, {8'b0, exp_mem['h58], 16'h0000});
    check("R2 page_x", {8'b0, page_x}, {8'b0, exp_mem['h59], 16'h0000});
    check("R2 page_y", {8'b0, page_y}, {8'b0, exp_mem['h5A], 16'h0000});
    check("R2 page_z", {8'b0, page_z}, {8'b0, exp_mem['h5B], 16'h0000});
    check("R4 page_ext", {8'b0, page_ext}, {8'b0, exp_mem['h5C], 16'h0000});
    check("R5/R6 stack_ptr", {16'b0, stack_ptr}, {16'b0, exp_mem['h5E], exp_mem['h5D]});
    check("R7 status_byte", {24'b0, status_byte}, {24'b0, exp_mem['h5F]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) begin
      ram_mem[i] = 8'hEE;
      exp_mem[i] = (i < 32 || (i >= 'h58 && i <= 'h5F)) ? 8'h00 : 8'hEE;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R10 ram_valid", {31'b0, ram_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 page_d", {8'b0, page_d}, 32'd0);
    check("R10 page_ext", {8'b0, page_ext}, 32'd0);
    check("R10 stack_ptr", {16'b0, stack_ptr}, 32'd0);
    check("R10 status_byte", {24'b0, status_byte}, 32'd0);
    access(1'b0, 16'h0007, 8'h00, rd);
    check("R10 gpr read", {24'b0, rd}, 32'd0);

    // straps on, no stall
    sweep(37, 5);

    // focused stack pointer low byte
    access(1'b1, 16'h005E, 8'hA5, rd);
    access(1'b1, 16'h005D, 8'h3C, rd);
    check("R6 sp high written", {16'b0, stack_ptr}, 32'h0000A53C);
    access(1'b1, 16'h005D, 8'h11, rd);
    check("R5 sp low only", {16'b0, stack_ptr}, 32'h0000A511);
    exp_mem['h5E] = 8'hA5; exp_mem['h5D] = 8'h11;

    // straps off, RAM stalls every other cycle
    strap_page_d = 1'b0; strap_page_x = 1'b0; strap_page_y = 1'b0; strap_page_z = 1'b0;
    strap_sp16 = 1'b0;
    stall_en = 1'b1;
    sweep(11, 'h93);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule